// File: doc/BRIEF.md
# Embedded-Controller Host Byte Port

This block is the controller side of a two-port host byte interface. The host sees a data port and a combined status/command port. It polls two handshake flags in the status byte. The input-full flag means the controller has not yet taken the last byte. The output-full flag means a byte is waiting for the host. The host moves commands, register addresses and data through these ports one byte at a time. An internal sequencer turns the byte stream into single-byte read and write strobes on a byte-addressed register file behind the block.

The sequencer understands five command codes: read, write, burst enable, burst disable and query. A read is a command byte followed by an address byte. The result comes back through the output buffer. A write is a command byte, an address byte and a data byte. Burst mode cuts the consume latency of the input buffer to one cycle and shows a flag in status. The query command is a stub that always answers with an empty event code. A third host port holds an interrupt-control byte as plain storage.

Top module: `ec_host_port`

## Requirements
- R1: After reset, the status byte, the data port and the interrupt-control byte all read 0x00.
- R2: A host write to port 0 (data) or port 1 (command) sets the input-full flag (status bit 1) from the next cycle. Status bit 3 is 1 when that byte was written to port 1 and 0 when it was written to port 0.
- R3: Outside burst mode, the input-full flag stays set for exactly IBF_LATENCY cycles after the write (default 4). It then clears by itself.
- R4: Command 0x80 followed by an address byte produces one reg_rd strobe at that address. The byte returned on reg_rdata is loaded into the output buffer, and the output-full flag (status bit 0) sets.
- R5: A host read of port 0 returns the output buffer and clears the output-full flag. If a new result is loaded in the same cycle, the load wins.
- R6: Command 0x81 followed by an address byte and a data byte produces one reg_wr strobe carrying that address and that data. reg_rd and reg_wr are never high together.
- R7: Command 0x82 sets the burst flag (status bit 4) and puts acknowledge byte 0x90 in the output buffer. In burst mode the input-full flag stays set for one cycle only. Command 0x83 clears the burst flag.
- R8: A command byte that arrives in the middle of a read or write sequence abandons that sequence with no strobe and starts the new command.
- R9: An undefined command code causes no strobe and no output byte, and the sequencer returns to idle. A data byte written to port 0 while idle is dropped.
- R10: A host write to port 0 or 1 in the same cycle the sequencer would consume the pending byte replaces that byte. The replaced byte is never acted on.
- R11: Command 0x84 loads the empty event code 0x00 into the output buffer and sets the output-full flag.
- R12: Port 2 reads back the last byte written to it and does not touch the input-full flag. Writes to port 3 have no effect, and port 3 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 2 | Host port select: 0 data, 1 status/command, 2 interrupt control |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effect on port 0 only) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for the selected port |
| reg_addr | output | 8 | Register file address |
| reg_wr | output | 1 | Register file write strobe |
| reg_rd | output | 1 | Register file read strobe |
| reg_wdata | output | 8 | Register file write byte |
| reg_rdata | input | 8 | Register file read byte, valid in the strobe cycle |

## Verification
Two events can land in the same cycle: a new host write and the sequencer consuming the byte still held in the input buffer. The bench provokes this on purpose. It issues a write command, counts off the latency, and writes a read command so that it lands exactly in the consume cycle. The outcome is correct only if no write strobe ever appears and the following address byte produces a single read whose result reaches the output buffer. This shows that the overwritten command was discarded rather than half-executed.

// File: rtl/ec_pkg.sv
package ec_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RD_ADDR,
        SQ_WR_ADDR,
        SQ_WR_DATA
    } seq_state_e;

    localparam logic [7:0] OP_READ      = 8'h80;
    localparam logic [7:0] OP_WRITE     = 8'h81;
    localparam logic [7:0] OP_BURST_ON  = 8'h82;
    localparam logic [7:0] OP_BURST_OFF = 8'h83;
    localparam logic [7:0] OP_QUERY     = 8'h84;

    localparam logic [7:0] BURST_ACK    = 8'h90;
    localparam logic [7:0] QUERY_EMPTY  = 8'h00;

    localparam logic [1:0] PORT_DATA = 2'd0;
    localparam logic [1:0] PORT_CMD  = 2'd1;
    localparam logic [1:0] PORT_ICR  = 2'd2;

    localparam int STS_OBF   = 0;
    localparam int STS_IBF   = 1;
    localparam int STS_CMD   = 3;
    localparam int STS_BURST = 4;

endpackage

// File: rtl/ec_input_buffer.sv
module ec_input_buffer #(
    parameter int LATENCY = 4,
    parameter int DW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_cmd,
    input  logic [DW-1:0] wr_byte,
    input  logic          burst,
    output logic          full,
    output logic          held_cmd,
    output logic          use_vld,
    output logic [DW-1:0] use_byte,
    output logic          use_cmd
);
    localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;

    typedef struct packed {
        logic          full;
        logic          cmd;
        logic [DW-1:0] data;
        logic [CW-1:0] cnt;
    } ib_t;

    ib_t ib_d, ib_q;

    always_comb begin
        ib_d    = ib_q;
        use_vld = 1'b0;
        if (wr_en) begin
            // a fresh host byte always replaces a pending one
            ib_d.full = 1'b1;
            ib_d.cmd  = wr_cmd;
            ib_d.data = wr_byte;
            ib_d.cnt  = burst ? '0 : CW'(LATENCY - 1);
        end else if (ib_q.full) begin
            if (ib_q.cnt == '0) begin
                use_vld   = 1'b1;
                ib_d.full = 1'b0;
            end else begin
                ib_d.cnt = ib_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ib_q <= '0;
        else        ib_q <= ib_d;
    end

    assign full     = ib_q.full;
    assign held_cmd = ib_q.cmd;
    assign use_byte = ib_q.data;
    assign use_cmd  = ib_q.cmd;

endmodule

// File: rtl/ec_output_buffer.sv
module ec_output_buffer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_byte,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);
    typedef struct packed {
        logic          full;
        logic [DW-1:0] data;
    } ob_t;

    ob_t ob_d, ob_q;

    always_comb begin
        ob_d = ob_q;
        if (load) begin
            ob_d.full = 1'b1;
            ob_d.data = load_byte;
        end else if (take) begin
            ob_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ob_q <= '0;
        else        ob_q <= ob_d;
    end

    assign full = ob_q.full;
    assign data = ob_q.data;

endmodule

// File: rtl/ec_sequencer.sv
module ec_sequencer
    import ec_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          use_vld,
    input  logic [DW-1:0] use_byte,
    input  logic          use_cmd,
    input  logic [DW-1:0] reg_rdata,
    output logic          reg_rd,
    output logic          reg_wr,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          ob_load,
    output logic [DW-1:0] ob_byte,
    output logic          burst
);
    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] addr;
        logic          burst;
    } sq_t;

    sq_t sq_d, sq_q;

    always_comb begin
        sq_d      = sq_q;
        reg_rd    = 1'b0;
        reg_wr    = 1'b0;
        ob_load   = 1'b0;
        ob_byte   = reg_rdata;
        reg_addr  = (sq_q.st == SQ_WR_DATA) ? sq_q.addr : AW'(use_byte);
        reg_wdata = use_byte;
        if (use_vld && use_cmd) begin
            // any command restarts the sequencer
            sq_d.st = SQ_IDLE;
            unique case (use_byte)
                OP_READ:      sq_d.st = SQ_RD_ADDR;
                OP_WRITE:     sq_d.st = SQ_WR_ADDR;
                OP_BURST_ON: begin
                    sq_d.burst = 1'b1;
                    ob_load    = 1'b1;
                    ob_byte    = BURST_ACK;
                end
                OP_BURST_OFF: sq_d.burst = 1'b0;
                OP_QUERY: begin
                    ob_load = 1'b1;
                    ob_byte = QUERY_EMPTY;
                end
                default: ;
            endcase
        end else if (use_vld) begin
            unique case (sq_q.st)
                SQ_RD_ADDR: begin
                    reg_rd  = 1'b1;
                    ob_load = 1'b1;
                    sq_d.st = SQ_IDLE;
                end
                SQ_WR_ADDR: begin
                    sq_d.addr = AW'(use_byte);
                    sq_d.st   = SQ_WR_DATA;
                end
                SQ_WR_DATA: begin
                    reg_wr  = 1'b1;
                    sq_d.st = SQ_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '{st: SQ_IDLE, addr: '0, burst: 1'b0};
        else        sq_q <= sq_d;
    end

    assign burst = sq_q.burst;

endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
    import ec_pkg::*;
#(
    parameter int IBF_LATENCY = 4,
    parameter int DW          = 8,
    parameter int AW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic [AW-1:0] reg_addr,
    output logic          reg_wr,
    output logic          reg_rd,
    output logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] reg_rdata
);
    logic          ib_wr, ibf, ib_cmd, use_vld, use_cmd;
    logic [DW-1:0] use_byte;
    logic          ob_load, ob_take, obf, burst;
    logic [DW-1:0] ob_byte, ob_data;
    logic [DW-1:0] icr_d, icr_q;
    logic [DW-1:0] sts;

    assign ib_wr   = host_wr && (host_addr == PORT_DATA || host_addr == PORT_CMD);
    assign ob_take = host_rd && (host_addr == PORT_DATA);

    ec_input_buffer #(.LATENCY(IBF_LATENCY), .DW(DW)) u_ib (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ib_wr),
        .wr_cmd   (host_addr == PORT_CMD),
        .wr_byte  (host_wdata),
        .burst    (burst),
        .full     (ibf),
        .held_cmd (ib_cmd),
        .use_vld  (use_vld),
        .use_byte (use_byte),
        .use_cmd  (use_cmd)
    );

    ec_sequencer #(.DW(DW), .AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .use_vld   (use_vld),
        .use_byte  (use_byte),
        .use_cmd   (use_cmd),
        .reg_rdata (reg_rdata),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ob_load   (ob_load),
        .ob_byte   (ob_byte),
        .burst     (burst)
    );

    ec_output_buffer #(.DW(DW)) u_ob (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ob_load),
        .load_byte (ob_byte),
        .take      (ob_take),
        .full      (obf),
        .data      (ob_data)
    );

    always_comb begin
        icr_d = icr_q;
        if (host_wr && host_addr == PORT_ICR) icr_d = host_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) icr_q <= '0;
        else        icr_q <= icr_d;
    end

    always_comb begin
        sts            = '0;
        sts[STS_OBF]   = obf;
        sts[STS_IBF]   = ibf;
        sts[STS_CMD]   = ib_cmd;
        sts[STS_BURST] = burst;
    end

    always_comb begin
        unique case (host_addr)
            PORT_DATA: host_rdata = ob_data;
            PORT_CMD:  host_rdata = sts;
            PORT_ICR:  host_rdata = icr_q;
            default:   host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ec_host_port_chk.sv
module ec_host_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] host_addr,
    input logic       host_wr,
    input logic       host_rd,
    input logic [7:0] sts,
    input logic       reg_rd,
    input logic       reg_wr,
    input logic       ob_load,
    input logic       burst
);
    assert_ibf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr < 2'd2) |=> sts[1]);

    assert_rd_loads_obf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> sts[0]);

    assert_obf_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 2'd0 && !ob_load) |=> !sts[0]);

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

    assert_burst_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && host_wr && host_addr < 2'd2) ##1 !host_wr |=> !sts[1]);

    assert_icr_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd2 && !sts[1]) |=> !sts[1]);
endmodule

bind ec_host_port ec_host_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .sts       (sts),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .ob_load   (ob_load),
    .burst     (burst)
);

// File: tb/ec_host_port_tb.sv
module ec_host_port_tb;
    localparam int LAT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = 2'd1;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [7:0] reg_addr;
    logic       reg_wr, reg_rd;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;

    logic [7:0] mem [256];
    int n_rd = 0;
    int n_wr = 0;
    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    ec_host_port #(.IBF_LATENCY(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (reg_rd) n_rd <= n_rd + 1;
        if (reg_wr) begin
            n_wr <= n_wr + 1;
            mem[reg_addr] <= reg_wdata;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic hwrite(input logic [1:0] port, input logic [7:0] val);
        host_addr = port; host_wdata = val; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_addr = 2'd1;
    endtask

    task automatic peek(input logic [1:0] port, output logic [7:0] val);
        host_addr = port; #1; val = host_rdata; host_addr = 2'd1;
    endtask

    task automatic hread_data(output logic [7:0] val);
        host_addr = 2'd0; host_rd = 1'b1; #1; val = host_rdata;
        @(negedge clk);
        host_rd = 1'b0; host_addr = 2'd1;
    endtask

    task automatic wait_ibf;
        logic [7:0] s;
        peek(2'd1, s);
        while (s[1]) begin
            @(negedge clk);
            peek(2'd1, s);
        end
    endtask

    task automatic send(input logic [1:0] port, input logic [7:0] val);
        hwrite(port, val);
        wait_ibf();
    endtask

    task automatic t_reset;
        logic [7:0] v;
        peek(2'd1, v); chk("R1 status", v, 8'h00);
        peek(2'd0, v); chk("R1 data", v, 8'h00);
        peek(2'd2, v); chk("R1 icr", v, 8'h00);
    endtask

    task automatic t_ibf_timing;
        logic [7:0] v;
        hwrite(2'd1, 8'h83);
        peek(2'd1, v); chk("R2 ibf+cmd bit", int'(v & 8'h0A), 8'h0A);
        for (int i = 1; i < LAT; i++) begin
            @(negedge clk); peek(2'd1, v); chk("R3 ibf held", int'(v[1]), 1);
        end
        @(negedge clk); peek(2'd1, v); chk("R3 ibf cleared", int'(v[1]), 0);
        hwrite(2'd0, 8'h11);
        peek(2'd1, v); chk("R2 data port cmd bit", int'(v & 8'h0A), 8'h02);
        wait_ibf();
    endtask

    task automatic t_read;
        logic [7:0] v;
        int r0 = n_rd;
        send(2'd1, 8'h80);
        send(2'd0, 8'h35);
        chk("R4 one read strobe", n_rd - r0, 1);
        peek(2'd1, v); chk("R4 obf set", int'(v[0]), 1);
        hread_data(v); chk("R4 read data", v, 8'hA7);
        peek(2'd1, v); chk("R5 obf cleared", int'(v[0]), 0);
    endtask

    task automatic t_write;
        logic [7:0] v;
        int w0 = n_wr;
        send(2'd1, 8'h81);
        send(2'd0, 8'h42);
        send(2'd0, 8'hC3);
        chk("R6 one write strobe", n_wr - w0, 1);
        chk("R6 written value", mem[8'h42], 8'hC3);
        peek(2'd1, v); chk("R6 no obf", int'(v[0]), 0);
    endtask

    task automatic t_burst;
        logic [7:0] v;
        send(2'd1, 8'h82);
        peek(2'd1, v); chk("R7 burst+obf", int'(v & 8'h11), 8'h11);
        hread_data(v); chk("R7 ack byte", v, 8'h90);
        hwrite(2'd1, 8'h83);
        peek(2'd1, v); chk("R7 ibf set", int'(v[1]), 1);
        @(negedge clk); peek(2'd1, v); chk("R7 one-cycle ibf", int'(v[1]), 0);
        chk("R7 burst cleared", int'(v[4]), 0);
    endtask

    task automatic t_abort;
        logic [7:0] v;
        int w0 = n_wr;
        logic [7:0] keep = mem[8'h10];
        send(2'd1, 8'h81);
        send(2'd0, 8'h10);
        send(2'd1, 8'h80);
        send(2'd0, 8'h35);
        chk("R8 no write after abort", n_wr - w0, 0);
        chk("R8 target untouched", mem[8'h10], keep);
        hread_data(v); chk("R8 new read done", v, 8'hA7);
    endtask

    task automatic t_undef;
        logic [7:0] v;
        int r0 = n_rd;
        int w0 = n_wr;
        send(2'd1, 8'hC5);
        send(2'd0, 8'h20);
        send(2'd0, 8'h21);
        chk("R9 no strobes", (n_rd - r0) + (n_wr - w0), 0);
        peek(2'd1, v); chk("R9 no obf", int'(v[0]), 0);
    endtask

    task automatic t_collide;
        logic [7:0] v;
        int r0 = n_rd;
        int w0 = n_wr;
        hwrite(2'd1, 8'h81);
        repeat (LAT - 1) @(negedge clk);
        hwrite(2'd1, 8'h80);   // lands in the consume cycle of 0x81
        wait_ibf();
        send(2'd0, 8'h35);
        chk("R10 no write strobe", n_wr - w0, 0);
        chk("R10 one read strobe", n_rd - r0, 1);
        hread_data(v); chk("R10 read data", v, 8'hA7);
    endtask

    task automatic t_query;
        logic [7:0] v;
        send(2'd1, 8'h84);
        peek(2'd1, v); chk("R11 obf set", int'(v[0]), 1);
        hread_data(v); chk("R11 empty code", v, 8'h00);
    endtask

    task automatic t_icr;
        logic [7:0] v;
        hwrite(2'd2, 8'h6C);
        peek(2'd1, v); chk("R12 no ibf", int'(v[1]), 0);
        peek(2'd2, v); chk("R12 icr readback", v, 8'h6C);
        hwrite(2'd3, 8'hFF);
        peek(2'd3, v); chk("R12 port3 zero", v, 8'h00);
        peek(2'd1, v); chk("R12 port3 no ibf", int'(v[1]), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        mem[8'h35] = 8'hA7;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ibf_timing();
        t_read();
        t_write();
        t_burst();
        t_abort();
        t_undef();
        t_collide();
        t_query();
        t_icr();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule